// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block tells the issue logic of an out-of-order core whether a memory instruction should wait for an older in-flight store. Instructions are grouped into store sets. A PC-indexed identifier table gives each instruction that has ever taken part in an ordering violation a set identifier. A per-set table records the sequence number of the most recently inserted store of that set. A lookup with a PC returns the sequence number of the store to wait for, or zero when no wait is predicted.

Stores are inserted at dispatch and are tracked in a small pending list until they issue or are squashed. When one leaves, its set's last-store entry is invalidated if that entry still names it. A violation report merges the offending store and load into one set. Software or the core can wipe all state at any time. The block also wipes itself after a programmable number of predicted memory operations, so that old sets do not pile up and cause false waits.

Top module: `store_set_predictor`

## Requirements
- R1: After reset, every lookup returns 0.
- R2: The identifier table is indexed by (PC >> OFFSET_BITS) & (ID_TABLE_ENTRIES-1). With defaults 2 and 64, PCs that differ only above bit 7 share an entry.
- R3: An instruction that gets a new identifier receives (store_pc ^ (store_pc >> 10)) mod SET_ENTRIES. With the default 16 this is the low four bits. Two sets whose store PCs hash to the same value share one last-store entry.
- R4: `lk_dep_seq` is combinational from `lk_pc`. It equals the last-store sequence number of the PC's set when both the identifier entry and that last-store entry are valid, and 0 otherwise.
- R5: A store insert writes its sequence number into the last-store entry of its set only when its identifier entry is valid. An insert with an invalid identifier entry changes no table.
- R6: A violation report handles three cases. When neither PC has a valid identifier, both get the hash of the store PC. When only one has a valid identifier, the other copies it. When both have one, both take the numerically smaller identifier.
- R7: An issue with sequence number N releases the tracked store N. Its set's last-store entry is invalidated only if that entry still holds N.
- R8: A squash with thread T and sequence number N releases every tracked store of thread T whose number is greater than N, with the same conditional invalidation. Other threads, and stores numbered N or lower, are kept.
- R9: `clr` invalidates every entry of both tables and the pending list at the next clock edge.
- R10: Each cycle with `lk_valid` high counts one predicted operation. At the edge on which the count reaches a nonzero `clear_period`, the block wipes as in R9 and the count restarts from 0. A `clear_period` of 0 never wipes.
- R11: In one cycle, a store insert's write to a last-store entry takes precedence over an issue or squash release of the same entry. A wipe takes precedence over everything.
- R12: The pending list holds PENDING_SLOTS stores. A store inserted while the list is full still updates its last-store entry, but it is not tracked, so its issue leaves that entry valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_period | input | CNT_W | Predicted operations between automatic wipes; 0 disables |
| lk_valid | input | 1 | Counts this cycle as one predicted operation |
| lk_pc | input | PC_W | PC to predict for |
| lk_dep_seq | output | SEQ_W | Sequence number of the store to wait for, or 0 |
| st_valid | input | 1 | Store insert strobe |
| st_pc | input | PC_W | Inserted store PC |
| st_seq | input | SEQ_W | Inserted store sequence number (nonzero) |
| st_tid | input | TID_W | Inserted store thread |
| vi_valid | input | 1 | Violation report strobe |
| vi_store_pc | input | PC_W | PC of the older store |
| vi_load_pc | input | PC_W | PC of the younger load |
| iss_valid | input | 1 | Store issue strobe |
| iss_seq | input | SEQ_W | Issued store sequence number |
| sq_valid | input | 1 | Squash strobe |
| sq_seq | input | SEQ_W | Squash boundary; younger stores are removed |
| sq_tid | input | TID_W | Squashed thread |
| clr | input | 1 | Global wipe |

## Verification
A store insert and a release of the same last-store entry, by squash or by issue, can land in the same cycle. The bench provokes this by leaving a store pending in a set. It then inserts a newer store of that set while squashing below the pending one, or while issuing the entry's current holder. A following lookup must show the newly inserted sequence number and not 0. Overlap of a wipe and an insert is judged the same way, and the expected lookup there is 0.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  // Which PCs of a violation already belong to a set
  typedef enum logic [1:0] {
    VC_NONE       = 2'd0,
    VC_STORE_ONLY = 2'd1,
    VC_LOAD_ONLY  = 2'd2,
    VC_BOTH       = 2'd3
  } vio_case_e;
endpackage

// File: rtl/ssp_id_table.sv
`timescale 1ns/1ps
module ssp_id_table #(
  parameter int PC_W        = 32,
  parameter int ENTRIES     = 64,
  parameter int OFFSET_BITS = 2,
  parameter int SET_ENTRIES = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wipe,
  input  logic [PC_W-1:0]                lk_pc,
  input  logic [PC_W-1:0]                st_pc,
  input  logic                           vi_valid,
  input  logic [PC_W-1:0]                vi_store_pc,
  input  logic [PC_W-1:0]                vi_load_pc,
  output logic                           lk_hit,
  output logic [$clog2(SET_ENTRIES)-1:0] lk_id,
  output logic                           st_hit,
  output logic [$clog2(SET_ENTRIES)-1:0] st_id
);
  import ssp_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int ID_W  = $clog2(SET_ENTRIES);

  logic [ENTRIES-1:0]  vld_q, vld_d;
  logic [ID_W-1:0]     id_q [ENTRIES];
  logic [ID_W-1:0]     id_d [ENTRIES];
  logic [IDX_W-1:0]    lk_idx, st_idx, vs_idx, vl_idx;
  logic [ID_W-1:0]     vs_hash, vs_cur, vl_cur, join_id;
  logic [PC_W-1:0]     hash_full;
  vio_case_e           vcase;
  logic                upd_en;

  // R2: index from the PC without its offset bits
  assign lk_idx = IDX_W'(lk_pc >> OFFSET_BITS);
  assign st_idx = IDX_W'(st_pc >> OFFSET_BITS);
  assign vs_idx = IDX_W'(vi_store_pc >> OFFSET_BITS);
  assign vl_idx = IDX_W'(vi_load_pc >> OFFSET_BITS);

  // R3: identifier for a fresh set
  assign hash_full = (vi_store_pc ^ (vi_store_pc >> 10)) % PC_W'(SET_ENTRIES);
  assign vs_hash   = ID_W'(hash_full);

  assign lk_hit = vld_q[lk_idx];
  assign lk_id  = id_q[lk_idx];
  assign st_hit = vld_q[st_idx];
  assign st_id  = id_q[st_idx];

  assign vs_cur = id_q[vs_idx];
  assign vl_cur = id_q[vl_idx];
  assign vcase  = vio_case_e'({vld_q[vl_idx], vld_q[vs_idx]});

  always_comb begin
    case (vcase)
      VC_NONE:       join_id = vs_hash;
      VC_STORE_ONLY: join_id = vs_cur;
      VC_LOAD_ONLY:  join_id = vl_cur;
      default:       join_id = (vs_cur < vl_cur) ? vs_cur : vl_cur;
    endcase
  end

  assign upd_en = wipe | vi_valid;

  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < ENTRIES; i++) id_d[i] = id_q[i];
    if (wipe) begin
      vld_d = '0;
    end else if (vi_valid) begin
      vld_d[vs_idx] = 1'b1;
      vld_d[vl_idx] = 1'b1;
      id_d[vs_idx]  = join_id;
      id_d[vl_idx]  = join_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) id_q[i] <= '0;
    end else if (upd_en) begin
      vld_q <= vld_d;
      for (int i = 0; i < ENTRIES; i++) id_q[i] <= id_d[i];
    end
  end

  // R6: after a report both PCs sit in one set
  assert_vio_join_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vi_valid && !wipe) |=> (vld_q[$past(vs_idx)] && vld_q[$past(vl_idx)] &&
                             id_q[$past(vs_idx)] == id_q[$past(vl_idx)]));

  // R9: a wipe leaves no valid identifier
  assert_wipe_ids_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (vld_q == '0));
endmodule

// File: rtl/ssp_last_store.sv
`timescale 1ns/1ps
module ssp_last_store #(
  parameter int SET_ENTRIES = 16,
  parameter int SEQ_W       = 16,
  parameter int SLOTS       = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wipe,
  input  logic                           ins_en,
  input  logic [$clog2(SET_ENTRIES)-1:0] ins_id,
  input  logic [SEQ_W-1:0]               ins_seq,
  input  logic [SLOTS-1:0]               rel_valid,
  input  logic [$clog2(SET_ENTRIES)-1:0] rel_id [SLOTS],
  input  logic [SEQ_W-1:0]               rel_seq [SLOTS],
  input  logic [$clog2(SET_ENTRIES)-1:0] lk_id,
  output logic                           lk_hit,
  output logic [SEQ_W-1:0]               lk_seq
);
  localparam int ID_W = $clog2(SET_ENTRIES);

  logic [SET_ENTRIES-1:0] vld_q, vld_d;
  logic [SEQ_W-1:0]       seq_q [SET_ENTRIES];
  logic [SEQ_W-1:0]       seq_d [SET_ENTRIES];
  logic                   upd_en;

  assign lk_hit = vld_q[lk_id];
  assign lk_seq = seq_q[lk_id];
  assign upd_en = wipe | ins_en | (|rel_valid);

  always_comb begin
    vld_d = vld_q;
    for (int e = 0; e < SET_ENTRIES; e++) seq_d[e] = seq_q[e];
    // R7/R8: drop the entry only if it still names the leaving store
    for (int s = 0; s < SLOTS; s++) begin
      if (rel_valid[s] && vld_q[rel_id[s]] && seq_q[rel_id[s]] == rel_seq[s])
        vld_d[rel_id[s]] = 1'b0;
    end
    // R11: the insert overrides a release of the same entry
    if (ins_en) begin
      vld_d[ins_id] = 1'b1;
      seq_d[ins_id] = ins_seq;
    end
    if (wipe) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int e = 0; e < SET_ENTRIES; e++) seq_q[e] <= '0;
    end else if (upd_en) begin
      vld_q <= vld_d;
      for (int e = 0; e < SET_ENTRIES; e++) seq_q[e] <= seq_d[e];
    end
  end

  // R5: an accepted insert is visible in its entry on the next cycle
  assert_ins_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !wipe) |=> (vld_q[$past(ins_id)] && seq_q[$past(ins_id)] == $past(ins_seq)));

  // R9: a wipe leaves no valid last-store entry
  assert_wipe_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (vld_q == '0));
endmodule

// File: rtl/ssp_pending.sv
`timescale 1ns/1ps
module ssp_pending #(
  parameter int SLOTS = 8,
  parameter int SEQ_W = 16,
  parameter int TID_W = 1,
  parameter int ID_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             push_en,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic [TID_W-1:0] push_tid,
  input  logic [ID_W-1:0]  push_id,
  input  logic             iss_valid,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic [TID_W-1:0] sq_tid,
  output logic [SLOTS-1:0] rel_valid,
  output logic [ID_W-1:0]  rel_id  [SLOTS],
  output logic [SEQ_W-1:0] rel_seq [SLOTS]
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0] vld_q, vld_d;
  logic [SEQ_W-1:0] seq_q [SLOTS];
  logic [TID_W-1:0] tid_q [SLOTS];
  logic [ID_W-1:0]  id_q  [SLOTS];
  logic [SLOTS-1:0] load_slot;
  logic [SLOT_W-1:0] free_idx;
  logic             have_free;

  // lowest free slot, taken from the state before this cycle's releases
  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        have_free = 1'b1;
        free_idx  = SLOT_W'(i);
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit_iss, hit_sq;
    assign hit_iss      = iss_valid && seq_q[g] == iss_seq;
    assign hit_sq       = sq_valid && tid_q[g] == sq_tid && seq_q[g] > sq_seq;
    assign rel_valid[g] = vld_q[g] && (hit_iss || hit_sq);
    assign rel_id[g]    = id_q[g];
    assign rel_seq[g]   = seq_q[g];
    // R12: a push with no free slot is not tracked
    assign load_slot[g] = push_en && have_free && free_idx == SLOT_W'(g) && !wipe;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seq_q[g] <= '0;
        tid_q[g] <= '0;
        id_q[g]  <= '0;
      end else if (load_slot[g]) begin
        seq_q[g] <= push_seq;
        tid_q[g] <= push_tid;
        id_q[g]  <= push_id;
      end
    end

    // R7/R8: a released slot is empty afterwards
    assert_release_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid[g] |=> !vld_q[g]);
  end

  always_comb begin
    vld_d = (vld_q & ~rel_valid) | load_slot;
    if (wipe) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end
endmodule

// File: rtl/ssp_clear_ctl.sv
`timescale 1ns/1ps
module ssp_clear_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             op_en,
  input  logic [CNT_W-1:0] period,
  output logic             wipe
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             reach;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  // R10: the operation that makes the count reach the period triggers the wipe
  assign reach = op_en && (period != '0) && (cnt_inc >= {1'b0, period});
  assign wipe  = clr | reach;

  always_comb begin
    cnt_d = cnt_q;
    if (wipe)       cnt_d = '0;
    else if (op_en) cnt_d = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (wipe || op_en)  cnt_q <= cnt_d;
  end

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !wipe) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_count_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (cnt_q == '0));
endmodule

// File: rtl/store_set_predictor.sv
`timescale 1ns/1ps
module store_set_predictor #(
  parameter int PC_W             = 32,
  parameter int SEQ_W            = 16,
  parameter int TID_W            = 1,
  parameter int ID_TABLE_ENTRIES = 64,
  parameter int SET_ENTRIES      = 16,
  parameter int OFFSET_BITS      = 2,
  parameter int PENDING_SLOTS    = 8,
  parameter int CNT_W            = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] clear_period,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  output logic [SEQ_W-1:0] lk_dep_seq,
  input  logic             st_valid,
  input  logic [PC_W-1:0]  st_pc,
  input  logic [SEQ_W-1:0] st_seq,
  input  logic [TID_W-1:0] st_tid,
  input  logic             vi_valid,
  input  logic [PC_W-1:0]  vi_store_pc,
  input  logic [PC_W-1:0]  vi_load_pc,
  input  logic             iss_valid,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic [TID_W-1:0] sq_tid,
  input  logic             clr
);
  localparam int ID_W = $clog2(SET_ENTRIES);

  logic                     wipe;
  logic                     lk_id_hit, lk_last_hit, st_id_hit, ins_en;
  logic [ID_W-1:0]          lk_id, st_id;
  logic [SEQ_W-1:0]         lk_last_seq;
  logic [PENDING_SLOTS-1:0] rel_valid;
  logic [ID_W-1:0]          rel_id  [PENDING_SLOTS];
  logic [SEQ_W-1:0]         rel_seq [PENDING_SLOTS];

  ssp_clear_ctl #(.CNT_W(CNT_W)) u_clear (
    .clk(clk), .rst_n(rst_n), .clr(clr), .op_en(lk_valid),
    .period(clear_period), .wipe(wipe)
  );

  ssp_id_table #(
    .PC_W(PC_W), .ENTRIES(ID_TABLE_ENTRIES),
    .OFFSET_BITS(OFFSET_BITS), .SET_ENTRIES(SET_ENTRIES)
  ) u_ids (
    .clk(clk), .rst_n(rst_n), .wipe(wipe),
    .lk_pc(lk_pc), .st_pc(st_pc),
    .vi_valid(vi_valid), .vi_store_pc(vi_store_pc), .vi_load_pc(vi_load_pc),
    .lk_hit(lk_id_hit), .lk_id(lk_id), .st_hit(st_id_hit), .st_id(st_id)
  );

  // R5: only stores that belong to a set are recorded
  assign ins_en = st_valid && st_id_hit;

  ssp_last_store #(
    .SET_ENTRIES(SET_ENTRIES), .SEQ_W(SEQ_W), .SLOTS(PENDING_SLOTS)
  ) u_last (
    .clk(clk), .rst_n(rst_n), .wipe(wipe),
    .ins_en(ins_en), .ins_id(st_id), .ins_seq(st_seq),
    .rel_valid(rel_valid), .rel_id(rel_id), .rel_seq(rel_seq),
    .lk_id(lk_id), .lk_hit(lk_last_hit), .lk_seq(lk_last_seq)
  );

  ssp_pending #(
    .SLOTS(PENDING_SLOTS), .SEQ_W(SEQ_W), .TID_W(TID_W), .ID_W(ID_W)
  ) u_pend (
    .clk(clk), .rst_n(rst_n), .wipe(wipe),
    .push_en(ins_en), .push_seq(st_seq), .push_tid(st_tid), .push_id(st_id),
    .iss_valid(iss_valid), .iss_seq(iss_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_tid(sq_tid),
    .rel_valid(rel_valid), .rel_id(rel_id), .rel_seq(rel_seq)
  );

  // R4: predicted producer, or zero
  assign lk_dep_seq = (lk_id_hit && lk_last_hit) ? lk_last_seq : '0;

  // R1/R9: the cycle after a wipe nothing is predicted
  assert_wipe_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wipe) |-> (lk_dep_seq == '0));
endmodule

// File: tb/tb_store_set_predictor.sv
`timescale 1ns/1ps
module tb_store_set_predictor;
  localparam int PC_W = 32, SEQ_W = 16, TID_W = 1, CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] clear_period;
  logic             lk_valid;
  logic [PC_W-1:0]  lk_pc;
  logic [SEQ_W-1:0] lk_dep_seq;
  logic             st_valid;
  logic [PC_W-1:0]  st_pc;
  logic [SEQ_W-1:0] st_seq;
  logic [TID_W-1:0] st_tid;
  logic             vi_valid;
  logic [PC_W-1:0]  vi_store_pc, vi_load_pc;
  logic             iss_valid;
  logic [SEQ_W-1:0] iss_seq;
  logic             sq_valid;
  logic [SEQ_W-1:0] sq_seq;
  logic [TID_W-1:0] sq_tid;
  logic             clr;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // set A: store 0x1004 (index 1, hash 0), load 0x2008 (index 2)
  localparam logic [31:0] PS  = 32'h1004;
  localparam logic [31:0] PL  = 32'h2008;
  localparam logic [31:0] PX  = 32'h0010; // index 4, hash 0
  localparam logic [31:0] PXL = 32'h0084; // index 33
  localparam logic [31:0] PS2 = 32'h0034; // index 13, hash 4
  localparam logic [31:0] PL2 = 32'h0044; // index 17
  localparam logic [31:0] PL3 = 32'h0054; // index 21
  localparam logic [31:0] PS3 = 32'h0064; // index 25
  localparam logic [31:0] PU  = 32'h3010; // index 4? no: 0xC04&63 = 4 -> avoid, used only before PX is set

  always #5 clk = ~clk;

  store_set_predictor dut (
    .clk(clk), .rst_n(rst_n), .clear_period(clear_period),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_dep_seq(lk_dep_seq),
    .st_valid(st_valid), .st_pc(st_pc), .st_seq(st_seq), .st_tid(st_tid),
    .vi_valid(vi_valid), .vi_store_pc(vi_store_pc), .vi_load_pc(vi_load_pc),
    .iss_valid(iss_valid), .iss_seq(iss_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_tid(sq_tid), .clr(clr)
  );

  function automatic logic [3:0] hash_id(input logic [31:0] pc);
    return 4'((pc ^ (pc >> 10)) % 16);
  endfunction

  task automatic check_lk(input logic [31:0] pc, input logic [15:0] exp, input string req);
    lk_pc = pc;
    #1;
    tests++;
    if (lk_dep_seq !== exp) begin
      fails++;
      $display("FAIL %s: lookup pc=%h got %0d expected %0d", req, pc, lk_dep_seq, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    st_valid = 0; vi_valid = 0; iss_valid = 0; sq_valid = 0; clr = 0; lk_valid = 0;
  endtask

  task automatic do_vio(input logic [31:0] s, input logic [31:0] l);
    vi_valid = 1; vi_store_pc = s; vi_load_pc = l; tick();
  endtask
  task automatic do_store(input logic [31:0] pc, input logic [15:0] seq, input logic tid);
    st_valid = 1; st_pc = pc; st_seq = seq; st_tid = tid; tick();
  endtask
  task automatic do_issue(input logic [15:0] seq);
    iss_valid = 1; iss_seq = seq; tick();
  endtask
  task automatic do_squash(input logic [15:0] seq, input logic tid);
    sq_valid = 1; sq_seq = seq; sq_tid = tid; tick();
  endtask
  task automatic do_clr;
    clr = 1; tick();
  endtask
  task automatic pulse_op;
    lk_valid = 1; tick();
  endtask

  task automatic t_reset;
    check_lk(PS, 0, "R1");
    check_lk(PL, 0, "R1");
  endtask

  task automatic t_basic;
    do_vio(PS, PL);
    do_store(PS, 10, 0);
    check_lk(PL, 10, "R4");
    check_lk(PS, 10, "R4");
    check_lk(PL2, 0, "R4");
    check_lk(PL + 32'h100, 10, "R2"); // same index as PL
    // PX hashes to set 0 but has no identifier yet
    do_store(PX, 11, 0);
    check_lk(PL, 10, "R5");
    check_lk(PX, 0, "R5");
    // fresh set for PX: hash of PX equals set of PS
    if (hash_id(PX) != hash_id(PS)) $display("bench setup mismatch");
    do_vio(PX, PXL);
    do_store(PX, 12, 0);
    check_lk(PL, 12, "R3");
    check_lk(PXL, 12, "R3");
  endtask

  task automatic t_issue;
    do_store(PS, 20, 0);
    do_issue(10); // entry now holds 20
    check_lk(PL, 20, "R7");
    do_issue(20);
    check_lk(PL, 0, "R7");
    do_issue(12);
  endtask

  task automatic t_squash;
    do_store(PS, 30, 0);
    do_squash(5, 1);
    check_lk(PL, 30, "R8");
    do_squash(30, 0);
    check_lk(PL, 30, "R8");
    do_squash(29, 0);
    check_lk(PL, 0, "R8");
  endtask

  task automatic t_violation;
    do_vio(PS2, PL2);                // neither valid: hash of PS2 = 4
    do_vio(PS, PL3);                 // only store valid: PL3 joins set 0
    do_store(PS, 40, 0);
    check_lk(PL3, 40, "R6");
    do_vio(PS3, PL);                 // only load valid: PS3 joins set 0
    do_store(PS3, 41, 0);
    check_lk(PL, 41, "R6");
    do_vio(PS2, PL);                 // both valid: smaller id 0 wins
    do_store(PS2, 42, 0);
    check_lk(PL, 42, "R6");
    check_lk(PL2, 0, "R6");          // set 4 never written
  endtask

  task automatic t_clear;
    do_clr();
    check_lk(PL, 0, "R9");
    check_lk(PS2, 0, "R9");
  endtask

  task automatic t_same_cycle;
    do_vio(PS, PL);
    do_store(PS, 50, 0);
    st_valid = 1; st_pc = PS; st_seq = 60; st_tid = 0;
    sq_valid = 1; sq_seq = 49; sq_tid = 0;
    tick();
    check_lk(PL, 60, "R11");
    st_valid = 1; st_pc = PS; st_seq = 61; st_tid = 0;
    iss_valid = 1; iss_seq = 60;
    tick();
    check_lk(PL, 61, "R11");
    st_valid = 1; st_pc = PS; st_seq = 62; st_tid = 0;
    clr = 1;
    tick();
    check_lk(PL, 0, "R11");
  endtask

  task automatic t_full;
    do_vio(PS, PL);
    for (int k = 0; k < 8; k++) do_store(PS, 16'(101 + k), 0);
    do_store(PS, 109, 0);             // list full: untracked
    do_issue(109);
    check_lk(PL, 109, "R12");
    do_clr();
  endtask

  task automatic t_periodic;
    clear_period = 3;
    do_vio(PS, PL);
    do_store(PS, 70, 0);
    pulse_op(); pulse_op();
    check_lk(PL, 70, "R10");
    pulse_op();
    check_lk(PL, 0, "R10");
    clear_period = 0;
    do_vio(PS, PL);
    do_store(PS, 71, 0);
    for (int k = 0; k < 6; k++) pulse_op();
    check_lk(PL, 71, "R10");
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clear_period = 0; lk_valid = 0; lk_pc = 0;
    st_valid = 0; st_pc = 0; st_seq = 0; st_tid = 0;
    vi_valid = 0; vi_store_pc = 0; vi_load_pc = 0;
    iss_valid = 0; iss_seq = 0; sq_valid = 0; sq_seq = 0; sq_tid = 0; clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_issue();
    t_squash();
    t_violation();
    t_clear();
    t_same_cycle();
    t_full();
    t_periodic();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule